// File: doc/BRIEF.md
# Multiplexed Bank Address Splitter

This block sits between a processor whose eight data pins also carry the upper address byte and the rest of a system built from ordinary peripherals. The processor's phase-2 clock decides what those shared pins mean. While phase 2 is low they hold address bits 23:16, which the block captures. While phase 2 is high they hold data, which the block passes on. The captured byte is joined to the 16-bit low address to form one 24-bit address.

The block also decodes the two cycle-type outputs of the processor into an address-valid flag and an opcode-fetch flag. From read/write, phase 2 and that validity it forms separate active-low read and write strobes. These strobes let peripherals with no native support for the bus ignore internal cycles, in which the address may be unsettled. When the processor runs in emulation mode, the captured bank is forced to zero.

Everything runs on a fast system clock that samples phase 2 and the bus as plain inputs. Every output is registered and reflects the inputs sampled at the previous rising edge of that clock.

Top module: `mux_bus_splitter`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `qaddr`=0, `addr_ok`=0, `opfetch`=0, `dbuf_en`=0, `dout`=0, `rd_n`=1 and `wr_n`=1, whatever the other inputs are.
- R2: If `phi2`=0 and `emu`=0 at a rising edge, `qaddr[23:16]` equals the `mbus` value sampled at that edge from the next cycle on.
- R3: If `phi2`=1 at a rising edge, `qaddr[23:16]` keeps the value it had before that edge.
- R4: If `phi2`=0 and `emu`=1 at a rising edge, `qaddr[23:16]` becomes 0 after that edge, whatever `mbus` holds.
- R5: `qaddr[15:0]` equals the `addr` value sampled at the previous rising edge.
- R6: The cycle type is {`vda`,`vpa`}: 00 internal, 01 program address, 10 data address, 11 opcode fetch. `addr_ok` is 1 after an edge where the type was not 00. `opfetch` is 1 after an edge where the type was 11.
- R7: `dbuf_en` equals the `phi2` value sampled at the previous edge. `dout` equals the sampled `mbus` when that `phi2` was 1, and 0 when it was 0.
- R8: `rd_n` is 0 exactly after an edge where `phi2`=1, `rw`=1 and the cycle type was not 00.
- R9: `wr_n` is 0 exactly after an edge where `phi2`=1, `rw`=0 and the cycle type was not 00.
- R10: After an internal cycle (type 00), both strobes are 1. `rd_n` and `wr_n` are never 0 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | Processor phase-2 level |
| addr | input | 16 | Low address bits 15:0 |
| mbus | input | 8 | Shared bank/data pins |
| rw | input | 1 | 1 = read, 0 = write |
| vda | input | 1 | Data-address cycle flag |
| vpa | input | 1 | Program-address cycle flag |
| emu | input | 1 | Emulation mode; forces the bank to zero |
| qaddr | output | 24 | Bank byte joined to the low address |
| addr_ok | output | 1 | Address is valid this cycle |
| opfetch | output | 1 | Cycle is an opcode fetch |
| dbuf_en | output | 1 | Data buffer enable (phase 2 high) |
| dout | output | 8 | Data passed through in phase 2 high, else 0 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The bench sweeps every combination of phase 2, read/write, the four cycle types and emulation mode. It does this under several bus byte patterns (all zeros, all ones, alternating bits and mixed nibbles), so that each bank bit and each data bit is seen at both levels. Pairing a low phase with a following high phase that carries a different byte separates correct holding from a latch that stays open. Emulation steps with nonzero bus bytes expose a bank that is not forced to zero. Running the internal cycle type with both read/write values and both phase levels shows whether a strobe ever escapes on an unqualified address.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  typedef enum logic [1:0] {
    CYC_INTERNAL = 2'b00,
    CYC_PROG     = 2'b01,
    CYC_DATA     = 2'b10,
    CYC_OPFETCH  = 2'b11
  } cyc_e;
endpackage

// File: rtl/bank_capture.sv
module bank_capture #(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phi2,
  input  logic              emu,
  input  logic [BANK_W-1:0] mbus,
  output logic [BANK_W-1:0] bank_q
);
  always_ff @(posedge clk) begin
    if (rst)        bank_q <= '0;
    else if (!phi2) bank_q <= emu ? '0 : mbus;
  end

  // R3
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    phi2 |=> $stable(bank_q));
  // R4
  bank_emu_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!phi2 && emu) |=> (bank_q == '0));
  // R2
  bank_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!phi2 && !emu) |=> (bank_q == $past(mbus)));
endmodule

// File: rtl/data_gate.sv
module data_gate #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phi2,
  input  logic [DATA_W-1:0] mbus,
  output logic              dbuf_en,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dbuf_en <= 1'b0;
      dout    <= '0;
    end else begin
      dbuf_en <= phi2;
      dout    <= phi2 ? mbus : '0;
    end
  end

  // R7
  data_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !phi2 |=> (!dbuf_en && dout == '0));
endmodule

// File: rtl/strobe_qual.sv
module strobe_qual
  import mux_bus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic phi2,
  input  logic rw,
  input  cyc_e cyc,
  output logic addr_ok,
  output logic opfetch,
  output logic rd_n,
  output logic wr_n
);
  logic valid;
  assign valid = (cyc != CYC_INTERNAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_ok <= 1'b0;
      opfetch <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
    end else begin
      addr_ok <= valid;
      opfetch <= (cyc == CYC_OPFETCH);
      rd_n    <= !(phi2 && rw && valid);
      wr_n    <= !(phi2 && !rw && valid);
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  // R10
  internal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_INTERNAL) |=> (rd_n && wr_n && !addr_ok));
  // R8
  read_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (phi2 && rw && cyc != CYC_INTERNAL) |=> !rd_n);
  // R9
  write_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (phi2 && !rw && cyc != CYC_INTERNAL) |=> !wr_n);
endmodule

// File: rtl/mux_bus_splitter.sv
module mux_bus_splitter
  import mux_bus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     phi2,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BANK_W-1:0]        mbus,
  input  logic                     rw,
  input  logic                     vda,
  input  logic                     vpa,
  input  logic                     emu,
  output logic [ADDR_W+BANK_W-1:0] qaddr,
  output logic                     addr_ok,
  output logic                     opfetch,
  output logic                     dbuf_en,
  output logic [BANK_W-1:0]        dout,
  output logic                     rd_n,
  output logic                     wr_n
);
  localparam int FULL_W = ADDR_W + BANK_W;

  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  cyc_e              cyc;

  assign cyc = cyc_e'({vda, vpa});

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr;
  end

  assign qaddr = {bank_q, addr_q};

  bank_capture #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst(rst), .phi2(phi2), .emu(emu), .mbus(mbus), .bank_q(bank_q)
  );

  data_gate #(.DATA_W(BANK_W)) u_data (
    .clk(clk), .rst(rst), .phi2(phi2), .mbus(mbus), .dbuf_en(dbuf_en), .dout(dout)
  );

  strobe_qual u_strb (
    .clk(clk), .rst(rst), .phi2(phi2), .rw(rw), .cyc(cyc),
    .addr_ok(addr_ok), .opfetch(opfetch), .rd_n(rd_n), .wr_n(wr_n)
  );

  // R5
  low_addr_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (qaddr[ADDR_W-1:0] == $past(addr)));
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (qaddr == FULL_W'(0) && rd_n && wr_n && !dbuf_en));
endmodule

// File: tb/sim_mux_bus_splitter.sv
module sim_mux_bus_splitter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phi2 = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  mbus = '0;
  logic        rw = 1'b1;
  logic        vda = 1'b0;
  logic        vpa = 1'b0;
  logic        emu = 1'b0;
  logic [23:0] qaddr;
  logic        addr_ok, opfetch, dbuf_en, rd_n, wr_n;
  logic [7:0]  dout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mux_bus_splitter u0 (
    .clk(clk), .rst(rst), .phi2(phi2), .addr(addr), .mbus(mbus), .rw(rw),
    .vda(vda), .vpa(vpa), .emu(emu), .qaddr(qaddr), .addr_ok(addr_ok),
    .opfetch(opfetch), .dbuf_en(dbuf_en), .dout(dout), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [7:0] exp_bank = 8'h00;

  task automatic step(input bit p, input bit r, input bit da, input bit pa, input bit e,
                      input logic [7:0] b, input logic [15:0] a);
    logic [7:0] prev_bank;
    bit v;
    @(negedge clk);
    phi2 = p; rw = r; vda = da; vpa = pa; emu = e; mbus = b; addr = a;
    prev_bank = exp_bank;
    if (!p) exp_bank = e ? 8'h00 : b;
    v = da | pa;
    @(posedge clk); #1;
    if (p)       chk(qaddr[23:16] == prev_bank, "R3 bank hold", qaddr[23:16], prev_bank);
    else if (e)  chk(qaddr[23:16] == 8'h00, "R4 emu bank", qaddr[23:16], 0);
    else         chk(qaddr[23:16] == b, "R2 bank capture", qaddr[23:16], b);
    chk(qaddr[15:0] == a, "R5 low addr", qaddr[15:0], a);
    chk(addr_ok == v, "R6 addr_ok", addr_ok, v);
    chk(opfetch == (da & pa), "R6 opfetch", opfetch, da & pa);
    chk(dbuf_en == p, "R7 dbuf_en", dbuf_en, p);
    chk(dout == (p ? b : 8'h00), "R7 dout", dout, p ? b : 8'h00);
    chk(rd_n == !(p && r && v), "R8 rd_n", rd_n, !(p && r && v));
    chk(wr_n == !(p && !r && v), "R9 wr_n", wr_n, !(p && !r && v));
    if (!v) chk(rd_n && wr_n, "R10 internal no strobe", {rd_n, wr_n}, 2'b11);
    chk(!(!rd_n && !wr_n), "R10 exclusive", {rd_n, wr_n}, 2'b11);
  endtask

  initial begin
    logic [7:0] pats [5];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h5A; pats[3] = 8'hA5; pats[4] = 8'h3C;
    // reset with busy inputs
    @(negedge clk);
    phi2 = 1'b1; rw = 1'b1; vda = 1'b1; vpa = 1'b1; mbus = 8'hC3; addr = 16'hBEEF;
    repeat (3) @(posedge clk);
    #1;
    chk(qaddr == 24'h0, "R1 qaddr", qaddr, 0);
    chk({addr_ok, opfetch, dbuf_en} == 3'b000, "R1 flags", {addr_ok, opfetch, dbuf_en}, 0);
    chk(dout == 8'h00, "R1 dout", dout, 0);
    chk(rd_n && wr_n, "R1 strobes", {rd_n, wr_n}, 2'b11);
    @(negedge clk); rst = 1'b0;
    exp_bank = 8'h00;
    for (int pi = 0; pi < 5; pi++) begin
      for (int c = 0; c < 32; c++) begin
        step(c[0], c[1], c[2], c[3], c[4], pats[pi] ^ 8'(c * 17), 16'(pi * 4099 + c * 257));
      end
    end
    // low phase then high phase with different byte: hold check
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, 16'h1234);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h5A, 16'h1235);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 16'h1236);
    // emulation with nonzero bus
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 16'hFFFE);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h77, 16'hFFFF);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule